// File: doc/BRIEF.md
# Processor interrupt level arbiter

This block sits on the processor side of an interrupt fabric. Fifteen interrupt level lines reach it as separate raise and lower strobes. It records them in a vector of pending levels and, on every clock, picks the highest pending level. From that level it forms an external-interrupt trap code and holds a hard interrupt request toward the trap logic.

The trap index register is shared with other trap sources. Those sources write it through a load port. While the index holds a code that is not an external interrupt, the arbiter leaves it alone, so a synchronous fault or software trap is never replaced by a device interrupt. The request is signalled anew, as a one-cycle kick, only when the chosen code actually changes. When the last pending level drops and the index still holds an external code, the arbiter clears both the index and the request.

Top module: `irq_level_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending vector, `trap_idx`, `hard_req` and `hard_kick` all become zero.
- R2: A pulse on `lvl_raise[n]` sets pending level n and a pulse on `lvl_drop[n]` clears it. When both strobe the same level in one cycle, the level ends up set. Bit n of both strobe vectors stands for level n, for n from 1 to 15.
- R3: When arbitration runs, `trap_idx` becomes 0x10 ORed with the highest pending level. The upper nibble 0x1 marks the external-interrupt type and the lower nibble carries the level, so codes span 0x11 to 0x1F. The index and the request update at the same clock edge that registers the strobe.
- R4: Arbitration loads a code only when `trap_idx` is zero or its upper nibble is 0x1. Any other index value stays unchanged while levels rise and fall.
- R5: `hard_req` is set whenever a code is loaded. `hard_kick` is high for exactly the one cycle that follows a load in which the new code differs from the previous index. A winner that does not change gives no kick.
- R6: When no level remains pending and `trap_idx` holds an external code, `trap_idx` returns to zero and `hard_req` drops.
- R7: A cycle with `trap_load` high writes `trap_load_val` into `trap_idx` and clears `hard_req` and `hard_kick`. In that cycle the load takes precedence over arbitration.
- R8: After the index is loaded with zero, pending levels are arbitrated again on the next cycle without any new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_raise | input | 15 | Per-level raise strobes, bit n is level n |
| lvl_drop | input | 15 | Per-level lower strobes, bit n is level n |
| trap_load | input | 1 | Write strobe from another trap source |
| trap_load_val | input | 8 | Index value written by `trap_load` |
| trap_idx | output | 8 | Current trap index |
| hard_req | output | 1 | Hard interrupt request level |
| hard_kick | output | 1 | One-cycle pulse when a new external code is presented |

## Verification
The bench first climbs through rising levels and then lowers the current winner. This shows that the code follows the highest pending bit and is not the most recent raise. A lower level raised under a higher one must produce no kick, which separates "code changed" from "any event". A raise and a drop on the same level in one cycle checks the set-wins ordering. Two further patterns load a non-interrupt index while levels arrive and then load zero, which separates blocking from forgetting pending levels. A final sweep raises and lowers each single level, to check every code value and the clear-on-empty path.

// File: rtl/lvl_arb_pkg.sv
// Package: shared constants for the interrupt level arbiter.
// Assumes levels are numbered from 1 and level 0 means "none".
package lvl_arb_pkg;
    localparam int unsigned NUM_LEVELS = 15;
    localparam int unsigned LVL_W      = $clog2(NUM_LEVELS + 1);
    localparam int unsigned IDX_W      = 8;
    localparam logic [IDX_W-1:0] EXT_TYPE = 8'h10;
endpackage

// File: rtl/lvl_pending.sv
// Module: lvl_pending
// Holds one pending bit per interrupt level. A raise and a drop on the
// same level in one cycle leave the level set.
// Assumes the strobes are synchronous to clk.
module lvl_pending #(
    parameter int unsigned NUM_LEVELS = lvl_arb_pkg::NUM_LEVELS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS:1]   set_i,
    input  logic [NUM_LEVELS:1]   clr_i,
    output logic [NUM_LEVELS:1]   pend_nxt_o,
    output logic [NUM_LEVELS:1]   pend_q_o
);
    logic [NUM_LEVELS:1] pend_q;

    // Next pending vector: apply the drop first, then the raise.
    always_comb begin
        pend_nxt_o = (pend_q & ~clr_i) | set_i;
    end

    // Pending register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt_o;
    end

    assign pend_q_o = pend_q;

    // A raised level must be pending after the edge (set wins).
    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
    // A dropped level that was not raised again must be gone.
    p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/lvl_prio.sv
// Module: lvl_prio
// Priority encoder: reports the highest set level of the vector.
// Assumes bit n of the vector stands for level n, from 1 upward.
module lvl_prio #(
    parameter int unsigned NUM_LEVELS = lvl_arb_pkg::NUM_LEVELS,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS + 1)
) (
    input  logic [NUM_LEVELS:1] vec_i,
    output logic                valid_o,
    output logic [LVL_W-1:0]    lvl_o
);
    // Ascending scan: the last hit, and so the highest level, wins.
    always_comb begin
        lvl_o = '0;
        for (int i = 1; i <= int'(NUM_LEVELS); i++) begin
            if (vec_i[i]) lvl_o = LVL_W'(i);
        end
    end

    assign valid_o = |vec_i;

    // Without a level the encoder must report zero.
    always_comb begin
        a_zero_when_empty_r3: assert (valid_o || lvl_o == '0);
    end
endmodule

// File: rtl/trap_sel.sv
// Module: trap_sel
// Owns the trap index, the hard request and the change kick. A load
// from another source wins. Otherwise external codes are loaded only
// over a zero or external index, and withdrawn when nothing is pending.
// Assumes the level fits in the low LVL_W bits of the index.
module trap_sel #(
    parameter int unsigned IDX_W   = lvl_arb_pkg::IDX_W,
    parameter int unsigned LVL_W   = lvl_arb_pkg::LVL_W,
    parameter logic [IDX_W-1:0] EXT_TYPE = lvl_arb_pkg::EXT_TYPE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_pend_i,
    input  logic [LVL_W-1:0]  sel_lvl_i,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  load_val_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              req_o,
    output logic              kick_o
);
    logic [IDX_W-1:0] idx_q, new_code;
    logic             req_q, kick_q, idx_is_ext, may_load;

    // Classify the current index and form the candidate code.
    always_comb begin
        idx_is_ext = (idx_q[IDX_W-1:LVL_W] == EXT_TYPE[IDX_W-1:LVL_W]);
        may_load   = (idx_q == '0) || idx_is_ext;
        new_code   = {EXT_TYPE[IDX_W-1:LVL_W], sel_lvl_i};
    end

    // Index, request and kick registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            req_q  <= 1'b0;
            kick_q <= 1'b0;
        end else if (load_i) begin
            idx_q  <= load_val_i;
            req_q  <= 1'b0;
            kick_q <= 1'b0;
        end else if (any_pend_i && may_load) begin
            idx_q  <= new_code;
            req_q  <= 1'b1;
            kick_q <= (new_code != idx_q);
        end else if (!any_pend_i && idx_is_ext) begin
            idx_q  <= '0;
            req_q  <= 1'b0;
            kick_q <= 1'b0;
        end else begin
            kick_q <= 1'b0;
        end
    end

    assign idx_o  = idx_q;
    assign req_o  = req_q;
    assign kick_o = kick_q;

    // A kick always comes with a changed index.
    p_kick_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_q |-> (idx_q != $past(idx_q)));
    // A raised request only accompanies an external code with a level.
    p_req_external_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (idx_q[IDX_W-1:LVL_W] == EXT_TYPE[IDX_W-1:LVL_W]
                   && idx_q[LVL_W-1:0] != '0));
    // A load wins over arbitration.
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_q == $past(load_val_i) && !req_q && !kick_q));
    // A foreign non-zero index is never replaced by arbitration.
    p_foreign_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !may_load) |=> $stable(idx_q));
endmodule

// File: rtl/irq_level_arbiter.sv
// Module: irq_level_arbiter (top)
// Collects level raise/drop strobes, selects the highest pending level
// and presents an external-interrupt trap code plus a hard request.
// Assumes all inputs are synchronous to clk; reset is synchronous, low.
module irq_level_arbiter #(
    parameter int unsigned NUM_LEVELS = lvl_arb_pkg::NUM_LEVELS,
    parameter int unsigned IDX_W      = lvl_arb_pkg::IDX_W,
    parameter logic [IDX_W-1:0] EXT_TYPE = lvl_arb_pkg::EXT_TYPE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS:1]   lvl_raise,
    input  logic [NUM_LEVELS:1]   lvl_drop,
    input  logic                  trap_load,
    input  logic [IDX_W-1:0]      trap_load_val,
    output logic [IDX_W-1:0]      trap_idx,
    output logic                  hard_req,
    output logic                  hard_kick
);
    localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1);

    logic [NUM_LEVELS:1] pend_nxt, pend_q;
    logic                sel_valid;
    logic [LVL_W-1:0]    sel_lvl;

    lvl_pending #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(lvl_raise), .clr_i(lvl_drop),
        .pend_nxt_o(pend_nxt), .pend_q_o(pend_q)
    );

    lvl_prio #(.NUM_LEVELS(NUM_LEVELS)) u_prio (
        .vec_i(pend_nxt), .valid_o(sel_valid), .lvl_o(sel_lvl)
    );

    trap_sel #(.IDX_W(IDX_W), .LVL_W(LVL_W), .EXT_TYPE(EXT_TYPE)) u_sel (
        .clk(clk), .rst_n(rst_n), .any_pend_i(sel_valid), .sel_lvl_i(sel_lvl),
        .load_i(trap_load), .load_val_i(trap_load_val),
        .idx_o(trap_idx), .req_o(hard_req), .kick_o(hard_kick)
    );

    // With nothing pending or raised, an external index is withdrawn.
    p_empty_withdraws_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_load && pend_q == '0 && lvl_raise == '0
         && trap_idx[IDX_W-1:LVL_W] == EXT_TYPE[IDX_W-1:LVL_W])
        |=> (trap_idx == '0 && !hard_req));
    // A zero index with pending levels and no load is replaced at once.
    p_rearb_after_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_load && trap_idx == '0 && pend_nxt != '0) |=> hard_req);
endmodule

// File: tb/tb_irq_level_arbiter.sv
module tb_irq_level_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] lvl_raise = '0, lvl_drop = '0;
    logic        trap_load = 1'b0;
    logic [7:0]  trap_load_val = '0;
    logic [7:0]  trap_idx;
    logic        hard_req, hard_kick;

    irq_level_arbiter dut (
        .clk(clk), .rst_n(rst_n), .lvl_raise(lvl_raise), .lvl_drop(lvl_drop),
        .trap_load(trap_load), .trap_load_val(trap_load_val),
        .trap_idx(trap_idx), .hard_req(hard_req), .hard_kick(hard_kick)
    );

    always #2 clk = ~clk; // 250 MHz

    int    n_vec = 0, n_bad = 0;
    bit    done = 1'b0;
    logic [9:0] exp_q[$];
    string tag_q[$];

    // Reference state, built from the requirements.
    logic [15:1] m_pend = '0;
    logic [7:0]  m_idx = '0;
    logic        m_req = 1'b0;

    task automatic step(input logic rst, input logic [15:1] s, input logic [15:1] c,
                        input logic ld, input logic [7:0] v, input string tag);
        logic [7:0] code;
        logic       kick;
        @(negedge clk);
        rst_n = ~rst; lvl_raise = s; lvl_drop = c; trap_load = ld; trap_load_val = v;
        kick = 1'b0;
        if (rst) begin
            m_pend = '0; m_idx = '0; m_req = 1'b0;
        end else begin
            m_pend = (m_pend & ~c) | s;
            if (ld) begin
                m_idx = v; m_req = 1'b0;
            end else if (m_pend != '0 && (m_idx == 8'h00 || m_idx[7:4] == 4'h1)) begin
                code = 8'h10;
                for (int i = 1; i <= 15; i++) if (m_pend[i]) code = 8'h10 | 8'(i);
                kick = (code != m_idx);
                m_idx = code; m_req = 1'b1;
            end else if (m_pend == '0 && m_idx[7:4] == 4'h1) begin
                m_idx = '0; m_req = 1'b0;
            end
        end
        exp_q.push_back({m_idx, m_req, kick});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one result per clock after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if ({trap_idx, hard_req, hard_kick} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got idx=%h req=%b kick=%b, expected idx=%h req=%b kick=%b",
                             t, trap_idx, hard_req, hard_kick, e[9:2], e[1], e[0]);
                end
            end
        end
    end

    function automatic logic [15:1] bit_of(input int n);
        logic [15:1] b;
        b = '0;
        b[n] = 1'b1;
        return b;
    endfunction

    initial begin
        step(1, '0, '0, 0, 0, "R1 reset");
        step(1, bit_of(4), '0, 0, 0, "R1 reset ignores raise");
        step(0, '0, '0, 0, 0, "R1 idle after reset");
        step(0, bit_of(3), '0, 0, 0, "R3 first level");
        step(0, bit_of(7), '0, 0, 0, "R3 higher level");
        step(0, bit_of(5), '0, 0, 0, "R5 lower level no kick");
        step(0, '0, bit_of(7), 0, 0, "R2 drop winner");
        step(0, bit_of(9), bit_of(9), 0, 0, "R2 raise wins over drop");
        step(0, '0, '0, 0, 0, "R5 steady no kick");
        step(0, '0, bit_of(9) | bit_of(5) | bit_of(3), 0, 0, "R6 empty withdraws");
        step(0, bit_of(15) | bit_of(1), '0, 0, 0, "R3 top level");
        step(0, bit_of(4), '0, 1, 8'h2A, "R7 load wins");
        step(0, bit_of(12), '0, 0, 0, "R4 foreign index held");
        step(0, '0, '1, 0, 0, "R4 held on empty");
        step(0, bit_of(6), '0, 0, 0, "R4 held on raise");
        step(0, '0, '0, 1, 8'h00, "R7 load zero");
        step(0, '0, '0, 0, 0, "R8 rearbitrate");
        step(0, '0, bit_of(6), 0, 0, "R6 clear last");
        for (int n = 1; n <= 15; n++) begin
            step(0, bit_of(n), '0, 0, 0, "R3 sweep raise");
            step(0, '0, bit_of(n), 0, 0, "R6 sweep drop");
        end
        step(0, bit_of(2), '0, 0, 0, "R3 before load ext");
        step(0, '0, '0, 1, 8'h1B, "R7 load external value");
        step(0, '0, '0, 0, 0, "R4 external index rearbitrated");
        step(1, '0, '0, 0, 0, "R1 reset mid-run");
        step(0, '0, '0, 0, 0, "R1 pending cleared");
        @(negedge clk);
        rst_n = 1'b1; lvl_raise = '0; lvl_drop = '0; trap_load = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule